// File: doc/BRIEF.md
# Serial Register Interface with Frame-Synchronised Commit

This block receives register writes over three wires: an active-low load strobe, a serial clock and a data line. All three inputs, together with a vertical sync input, are brought into the register clock domain through synchroniser chains. Rising edges of the serial clock are then detected in that domain. A write names an 8-bit start address and carries one or more 16-bit data words. Both address and data are sent least significant bit first. Each extra word that arrives while the strobe stays low goes to the next address. The register bank is presented as one flat output bus of sixteen 16-bit slots, slot N at bits [16N+15:16N].

Three registers can be held back: the analog gain select at slot 2, the amplifier gain at slot 3 and the black level target at slot 4. Each has a select bit in the staging mask at slot 14. When its select bit is set, a write lands in a shadow copy, and the shadow moves to the live register on the chosen vertical sync edge. Bit 0 of slot 13 chooses that edge. Writing 1 to bit 0 of slot 11 returns the whole bank to its defaults, and that bit then reads 0 again.

The receiver is a state machine with three states. RX_IDLE is the state while the strobe is high. It goes to RX_ADDR when the strobe falls. RX_ADDR shifts in 8 address bits and goes to RX_DATA on the 8th rising clock. RX_DATA shifts in 16-bit words. On each 16th bit it issues a write and increments the address, and it stays in RX_DATA. A rising strobe takes RX_ADDR or RX_DATA back to RX_IDLE and drops any partly received word.

Top module: `serial_regif`

## Requirements
- R1: One frame is a low strobe, 8 address bits, then 16 data bits, each field LSB first. It writes the data word to the addressed slot.
- R2: Data is sampled only on rising serial clock edges while the strobe is low. The clock may idle high or low between frames, and clock edges while the strobe is high change nothing.
- R3: Each further 16-bit word sent under the same low strobe goes to the next higher address. Addresses 15 and above are not stored.
- R4: If the strobe rises before all 16 bits of a word have arrived, that word is discarded and no slot changes.
- R5: A live slot changes only because of a completed word, a sync commit or a software reset. An immediate slot does not change after 15 data bits, and it takes the new value once the 16th bit is clocked in.
- R6: When staging mask bit 0, 1 or 2 (slot 14) is set, a write to slot 2, 3 or 4 respectively goes to that slot's shadow only. On a commit, each selected slot takes its shadow value. When the mask bit is clear, the write is immediate.
- R7: The commit happens on the falling edge of vertical sync when slot 13 bit 0 is 0, and on the rising edge when it is 1. The other edge does nothing.
- R8: Writing 1 to slot 11 bit 0 restores every slot and shadow to its default one cycle later, and slot 11 then reads 0.
- R9: After reset, the slots hold their defaults: slot 0 = 0x504 (bit 2 set), slot 2 = 0x1, slot 3 = 0x00F, slot 4 = 0x1EC, slot 6 = 0x6, slots 8 and 9 = 0xFFF, slot 12 = 0x1, and all other slots 0.
- R10: Data bits above a slot's width read as 0. The widths for slots 0 to 15 are 11, 7, 3, 10, 11, 4, 6, 1, 12, 12, 1, 1, 1, 1, 7 and 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous reset, active high |
| sl_n | input | 1 | Load strobe, frame active while low |
| sck | input | 1 | Serial clock, data taken on rising edge |
| sdata | input | 1 | Serial data, LSB first |
| vsync | input | 1 | Vertical sync, commits staged slots |
| regs_o | output | 256 | Flat bank contents, slot N at [16N+15:16N] |

## Verification
Single frames are sent with the clock idling low and with it idling high. These show whether edges are detected only while the strobe is low, and whether the idle level leaks a spurious bit. Bursts, including one that runs past the last slot, tell correct address increment apart from an address held in place or wrapped into low slots. Words cut short at 10 and 5 bits, and a word held at 15 bits, separate discard-on-strobe from early commit. Staged writes followed by each sync edge under both polarity settings show whether the shadow path and the edge choice work. A randomised run of bursts with random clock idle levels, masks and polarity is compared against a bench model of the bank.

// File: rtl/tws_pkg.sv
package tws_pkg;

    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 16;
    localparam int REG_COUNT = 16;

    // slots whose position other logic decodes
    localparam int A_CDS        = 2;
    localparam int A_VGA        = 3;
    localparam int A_CLAMP      = 4;
    localparam int A_SWRST      = 11;
    localparam int A_SYNCPOL    = 13;
    localparam int A_STAGE_MASK = 14;
    localparam int N_STAGED     = A_CLAMP - A_CDS + 1;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_ADDR = 2'd1,
        RX_DATA = 2'd2
    } rx_state_t;

    function automatic int slot_width(input int a);
        case (a)
            0:       return 11;
            1:       return 7;
            2:       return 3;
            3:       return 10;
            4:       return 11;
            5:       return 4;
            6:       return 6;
            8, 9:    return 12;
            14:      return 7;
            7, 10, 11, 12, 13: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] slot_mask(input int a);
        int w;
        w = slot_width(a);
        if (w == 0) return '0;
        return {DATA_W{1'b1}} >> (DATA_W - w);
    endfunction

    function automatic logic [DATA_W-1:0] slot_default(input int a);
        case (a)
            0:       return 16'h0504;
            2:       return 16'h0001;
            3:       return 16'h000F;
            4:       return 16'h01EC;
            6:       return 16'h0006;
            8, 9:    return 16'h0FFF;
            12:      return 16'h0001;
            default: return 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/tws_rx.sv
module tws_rx
    import tws_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sl_n,
    input  logic          sck,
    input  logic          sdata,
    output logic          wr_stb,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    localparam int            CNT_W     = $clog2(DW);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(AW - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DW - 1);

    rx_state_t        state_q, state_d;
    logic             sck_q;
    logic             sck_rise;
    logic [CNT_W-1:0] bit_cnt;
    logic [AW-1:0]    addr_q;
    logic [DW-2:0]    shift_q;

    assign sck_rise = sck & ~sck_q;

    always_ff @(posedge clk) begin
        if (rst) sck_q <= 1'b0;
        else     sck_q <= sck;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= RX_IDLE;
        else     state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: if (!sl_n) state_d = RX_ADDR;
            RX_ADDR: begin
                if (sl_n)                                 state_d = RX_IDLE;
                else if (sck_rise && bit_cnt == ADDR_LAST) state_d = RX_DATA;
            end
            RX_DATA: if (sl_n) state_d = RX_IDLE;
            default: state_d = RX_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
            addr_q  <= '0;
            shift_q <= '0;
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= 1'b0;
            unique case (state_q)
                RX_IDLE: bit_cnt <= '0;
                RX_ADDR: begin
                    if (sl_n) begin
                        bit_cnt <= '0;
                    end else if (sck_rise) begin
                        addr_q  <= {sdata, addr_q[AW-1:1]};
                        bit_cnt <= (bit_cnt == ADDR_LAST) ? '0 : bit_cnt + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (sl_n) begin
                        bit_cnt <= '0;
                    end else if (sck_rise) begin
                        shift_q <= {sdata, shift_q[DW-2:1]};
                        if (bit_cnt == DATA_LAST) begin
                            wr_stb  <= 1'b1;
                            wr_addr <= addr_q;
                            wr_data <= {sdata, shift_q};
                            addr_q  <= addr_q + 1'b1;
                            bit_cnt <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                default: bit_cnt <= '0;
            endcase
        end
    end
endmodule

// File: rtl/tws_commit.sv
module tws_commit (
    input  logic clk,
    input  logic rst,
    input  logic vs,
    input  logic rise_sel,
    output logic commit
);
    logic vs_q;
    logic edge_hit;

    assign edge_hit = rise_sel ? (vs & ~vs_q) : (~vs & vs_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            vs_q   <= 1'b0;
            commit <= 1'b0;
        end else begin
            vs_q   <= vs;
            commit <= edge_hit;
        end
    end
endmodule

// File: rtl/tws_bank.sv
module tws_bank
    import tws_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int NR = REG_COUNT
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_stb,
    input  logic [AW-1:0]  wr_addr,
    input  logic [DW-1:0]  wr_data,
    input  logic           commit,
    output logic [NR*DW-1:0] regs
);
    logic soft_rst;
    assign soft_rst = regs[A_SWRST*DW];

    for (genvar g = 0; g < NR; g++) begin : g_slot
        localparam logic [DW-1:0] DEF   = slot_default(g);
        localparam logic [DW-1:0] WMASK = slot_mask(g);
        logic          hit;
        logic [DW-1:0] q;

        assign hit = wr_stb && (wr_addr == AW'(g));
        assign regs[g*DW +: DW] = q;

        if (g >= A_CDS && g <= A_CLAMP) begin : g_staged
            logic          sel;
            logic [DW-1:0] shadow_q;
            assign sel = regs[A_STAGE_MASK*DW + (g - A_CDS)];

            always_ff @(posedge clk) begin
                if (rst || soft_rst) begin
                    q        <= DEF;
                    shadow_q <= DEF;
                end else begin
                    if (hit) shadow_q <= wr_data & WMASK;
                    if (hit && !sel)        q <= wr_data & WMASK;
                    else if (commit && sel) q <= shadow_q;
                end
            end
        end else begin : g_direct
            always_ff @(posedge clk) begin
                if (rst || soft_rst) q <= DEF;
                else if (hit)        q <= wr_data & WMASK;
            end
        end
    end
endmodule

// File: rtl/serial_regif.sv
module serial_regif
    import tws_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int AW          = ADDR_W,
    parameter int DW          = DATA_W,
    parameter int NR          = REG_COUNT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sl_n,
    input  logic             sck,
    input  logic             sdata,
    input  logic             vsync,
    output logic [NR*DW-1:0] regs_o
);
    logic [3:0]    raw, synced;
    logic          wr_stb;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic          commit;

    assign raw = {vsync, sdata, sck, sl_n};

    tws_sync #(
        .WIDTH  (4),
        .STAGES (SYNC_STAGES),
        .RST_VAL(4'b0001)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (raw),
        .q  (synced)
    );

    tws_rx #(.AW(AW), .DW(DW)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .sl_n   (synced[0]),
        .sck    (synced[1]),
        .sdata  (synced[2]),
        .wr_stb (wr_stb),
        .wr_addr(wr_addr),
        .wr_data(wr_data)
    );

    tws_commit u_commit (
        .clk     (clk),
        .rst     (rst),
        .vs      (synced[3]),
        .rise_sel(regs_o[A_SYNCPOL*DW]),
        .commit  (commit)
    );

    tws_bank #(.AW(AW), .DW(DW), .NR(NR)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_stb (wr_stb),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .commit (commit),
        .regs   (regs_o)
    );
endmodule

// File: rtl/serial_regif_chk.sv
module serial_regif_chk (
    input logic         clk,
    input logic         rst,
    input logic         wr_stb,
    input logic         commit,
    input logic [255:0] regs
);
    AST_WRITE_PULSE: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb); // R1

    AST_LIVE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (!wr_stb && !commit && !regs[11*16]) |=> $stable(regs)); // R5

    AST_STAGED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (regs[14*16+1] && !commit && !regs[11*16]) |=> $stable(regs[3*16 +: 16])); // R6

    AST_SWRST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        regs[11*16] |=> (!regs[11*16] && regs[3*16 +: 16] == 16'h000F)); // R8

    AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (regs[2*16 +: 16] == 16'h0001 && regs[3*16 +: 16] == 16'h000F
                        && regs[4*16 +: 16] == 16'h01EC && regs[2])); // R9

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (regs[2*16+3 +: 13] == '0 && regs[3*16+10 +: 6] == '0
         && regs[4*16+11 +: 5] == '0 && regs[15*16 +: 16] == '0)); // R10
endmodule

bind serial_regif serial_regif_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .wr_stb(wr_stb),
    .commit(commit),
    .regs  (regs_o)
);

// File: tb/sim_serial_regif.sv
`timescale 1ns/1ps
module sim_serial_regif;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sl_n = 1'b1;
    logic         sck = 1'b0;
    logic         sdata = 1'b0;
    logic         vsync = 1'b0;
    logic [255:0] regs_o;

    int n_checks = 0;
    int n_fail   = 0;

    logic [15:0] exp_r  [16];
    logic [15:0] exp_sh [3];
    logic [15:0] wbuf   [8];

    always #4 clk = ~clk;

    serial_regif u0 (
        .clk(clk), .rst(rst), .sl_n(sl_n), .sck(sck),
        .sdata(sdata), .vsync(vsync), .regs_o(regs_o)
    );

    function automatic int bw(input int a);
        int t [16] = '{11, 7, 3, 10, 11, 4, 6, 1, 12, 12, 1, 1, 1, 1, 7, 0};
        return t[a];
    endfunction

    function automatic logic [15:0] bdef(input int a);
        logic [15:0] t [16] = '{16'h504, 0, 16'h1, 16'hF, 16'h1EC, 0, 16'h6, 0,
                                 16'hFFF, 16'hFFF, 0, 0, 16'h1, 0, 0, 0};
        return t[a];
    endfunction

    function automatic logic [15:0] bmask(input int a);
        return 16'((32'd1 << bw(a)) - 1);
    endfunction

    task automatic model_reset();
        for (int a = 0; a < 16; a++) exp_r[a] = bdef(a);
        for (int i = 0; i < 3; i++) exp_sh[i] = bdef(2 + i);
    endtask

    task automatic model_write(input logic [7:0] a, input logic [15:0] d);
        logic [15:0] v;
        if (a >= 16) return;
        v = d & bmask(int'(a));
        if (a == 11 && v[0]) begin
            model_reset();
        end else if (a >= 2 && a <= 4) begin
            exp_sh[a-2] = v;
            if (!exp_r[14][a-2]) exp_r[a] = v;
        end else begin
            exp_r[a] = v;
        end
    endtask

    task automatic model_commit();
        for (int i = 0; i < 3; i++) if (exp_r[14][i]) exp_r[2+i] = exp_sh[i];
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_all(input string req);
        int bad;
        bad = 0;
        n_checks++;
        for (int a = 0; a < 16; a++) begin
            if (regs_o[a*16 +: 16] !== exp_r[a]) begin
                $display("FAIL %s slot %0d got %h exp %h", req, a, regs_o[a*16 +: 16], exp_r[a]);
                bad = 1;
            end
        end
        if (bad) n_fail++;
    endtask

    task automatic bit_out(input logic b);
        sck = 1'b0; sdata = b; wait_clk(4);
        sck = 1'b1; wait_clk(4);
    endtask

    task automatic send_bits(input logic [15:0] v, input int n);
        for (int i = 0; i < n; i++) bit_out(v[i]);
    endtask

    task automatic open_frame(input logic [7:0] a);
        sl_n = 1'b0; wait_clk(4);
        send_bits({8'h00, a}, 8);
    endtask

    task automatic close_frame(input logic idle);
        wait_clk(4);
        sl_n = 1'b1; sck = idle; wait_clk(12);
    endtask

    task automatic do_frame(input logic [7:0] a, input int nw, input int tail, input logic idle);
        sck = idle; wait_clk(4);
        open_frame(a);
        for (int w = 0; w < nw; w++) begin
            send_bits(wbuf[w], 16);
            model_write(8'(a + w), wbuf[w]);
        end
        if (tail > 0) send_bits(16'hFFFF, tail);
        close_frame(idle);
    endtask

    task automatic vs_drive(input logic v);
        vsync = v; wait_clk(12);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog expired: cycles got 150000 exp fewer");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        wait_clk(5);
        rst = 1'b0;
        wait_clk(3);
        check_all("R9 reset defaults");

        // R1 single frame, clock idle low
        wbuf[0] = 16'h02A5; do_frame(8'd3, 1, 0, 1'b0);
        check_all("R1 single write");

        // R2 clock idle high, then clock activity with strobe high
        wbuf[0] = 16'h0055; do_frame(8'd1, 1, 0, 1'b1);
        check_all("R2 idle high");
        for (int i = 0; i < 10; i++) begin
            sdata = i[0]; sck = 1'b0; wait_clk(4); sck = 1'b1; wait_clk(4);
        end
        wait_clk(8);
        check_all("R2 clock with strobe high");

        // R3 burst
        wbuf[0] = 16'h000A; wbuf[1] = 16'h0033; wbuf[2] = 16'h0001;
        do_frame(8'd5, 3, 0, 1'b0);
        check_all("R3 burst increment");
        wbuf[0] = 16'h0000; wbuf[1] = 16'h0000; wbuf[2] = 16'hBEEF; wbuf[3] = 16'h1234;
        do_frame(8'd13, 4, 0, 1'b1);
        check_all("R3 burst past last slot");

        // R4 partial words
        do_frame(8'd4, 0, 10, 1'b0);
        check_all("R4 partial single");
        wbuf[0] = 16'h0ABC; do_frame(8'd8, 1, 5, 1'b0);
        check_all("R4 partial after full word");

        // R5 no update at 15 bits, update at 16th
        sck = 1'b0; wait_clk(4);
        open_frame(8'd0);
        send_bits(16'h0123, 15);
        wait_clk(12);
        check_all("R5 held at 15 bits");
        bit_out(1'b0);
        model_write(8'd0, 16'h0123);
        wait_clk(12);
        check_all("R5 commit on 16th bit");
        close_frame(1'b0);

        // R10 width truncation
        wbuf[0] = 16'hFFFF; do_frame(8'd2, 1, 0, 1'b0);
        check_all("R10 width slot 2");
        wbuf[0] = 16'hFFFF; do_frame(8'd10, 1, 0, 1'b0);
        check_all("R10 width slot 10");

        // R6 / R7 staged writes
        wbuf[0] = 16'h0007; do_frame(8'd14, 1, 0, 1'b0);
        wbuf[0] = 16'h0002; wbuf[1] = 16'h0123; wbuf[2] = 16'h00AA;
        do_frame(8'd2, 3, 0, 1'b0);
        check_all("R6 staged not live");
        vs_drive(1'b1);
        check_all("R7 rising ignored when falling selected");
        vs_drive(1'b0); model_commit();
        check_all("R7 falling edge commit");
        wbuf[0] = 16'h0001; do_frame(8'd13, 1, 0, 1'b0);
        wbuf[0] = 16'h03FF; do_frame(8'd3, 1, 0, 1'b1);
        check_all("R6 staged again");
        vs_drive(1'b1); model_commit();
        check_all("R7 rising edge commit");
        vs_drive(1'b0);
        check_all("R7 falling ignored when rising selected");
        wbuf[0] = 16'h0002; do_frame(8'd14, 1, 0, 1'b0);
        wbuf[0] = 16'h0003; do_frame(8'd2, 1, 0, 1'b0);
        check_all("R6 unselected slot immediate");

        // R8 software reset
        wbuf[0] = 16'h0001; do_frame(8'd11, 1, 0, 1'b0);
        check_all("R8 soft reset");

        // random bursts
        for (int it = 0; it < 40; it++) begin
            logic [7:0] a;
            int         nw;
            logic       idle;
            a    = 8'($urandom_range(0, 15));
            nw   = $urandom_range(1, 3);
            idle = 1'($urandom_range(0, 1));
            for (int w = 0; w < nw; w++) begin
                wbuf[w] = 16'($urandom);
                if (8'(a + w) == 8'd11) wbuf[w][0] = 1'b0;
            end
            do_frame(a, nw, ($urandom_range(0, 3) == 0) ? $urandom_range(1, 15) : 0, idle);
            check_all("R1 random burst");
        end
        vs_drive(1'b1); vs_drive(1'b0); model_commit();
        check_all("R6 random commit");

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule